// File: doc/BRIEF.md
# Camellia Single-Step Round Engine

This block holds a 128-bit Camellia working state as two 64-bit words, called the left word (word 0) and the right word (word 1). Software drives it through a write port that carries a selector code, a 64-bit operand and a valid strobe. Each accepted command performs one step of the cipher, with the operand used as the subkey for that step. The steps are a Feistel round, the forward FL diffusion layer applied to the left word, and the inverse FL layer applied to the right word. Two further selector codes load either word directly. A combinational read port returns whichever word is selected.

The key schedule, block sequencing, whitening and modes of operation all stay in software. A complete encryption is a stream of commands: load the whitened plaintext, issue eighteen rounds with the FL and inverse-FL pair after the sixth and after the twelfth round, then read both words back. Every command takes effect at the clock edge that samples it, so the result can be read in the next cycle.

Top module: `camStepEngine`

## Requirements
- R1: After an asynchronous active-low reset, both state words read as zero.
- R2: When wrValid is high, selector 0x0100 loads wrData into the left word and selector 0x0101 loads wrData into the right word. rdSel=0 returns the left word and rdSel=1 returns the right word, and the new value is visible in the cycle after the write.
- R3: When wrValid is high with selector 0x3114 (round), the engine sets the left word to right XOR F(left, wrData) and the right word to the old left, both in the same clock edge.
- R4: F forms x = input XOR subkey. It passes the eight bytes of x, most significant byte first, through the S-boxes s1, s2, s3, s4, s2, s3, s4, s1. s1 is the standard Camellia substitution table, with s1(0)=0x70. s2 is s1 rotated left by one bit, s3 is s1 rotated left by seven bits, and s4(x) is s1 of x rotated left by one bit. As a result, F(0, 0) = 0x00000000A838E0A8.
- R5: The eight S-box outputs t1..t8 are mixed by the fixed Camellia XOR network into bytes y1..y8, and y1 is placed in the most significant byte of the F output.
- R6: Selector 0x0115 replaces the left word with FL(left, wrData) and leaves the right word unchanged. FL splits the data and the key into 32-bit halves (high half first). It first XORs the low data half with the high data half AND the high key half, rotated left by one bit. It then XORs the high data half with the new low data half OR the low key half.
- R7: Selector 0x0116 replaces the right word with FL⁻¹(right, wrData) and leaves the left word unchanged. FL⁻¹ performs the two FL steps in reverse order, so FL⁻¹(FL(v, k), k) = v.
- R8: A write with wrValid low, or a write with any selector other than the five listed, leaves both words unchanged.
- R9: A command stream made of loads, rounds and FL/FL⁻¹ steps with a 128-bit-key Camellia schedule produces the published ciphertext 0x67673138549669730857065648EABE43 for key and plaintext 0x0123456789ABCDEFFEDCBA9876543210.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | Qualifies a command on wrSel and wrData |
| wrSel | input | 16 | Command selector code |
| wrData | input | 64 | Subkey operand, or the value for a direct load |
| rdSel | input | 1 | Chooses the word on rdData (0 left, 1 right) |
| rdData | output | 64 | Selected state word |

## Verification
The assertions assume that wrSel and wrData are known whenever wrValid is high, and that at most one command arrives per clock. This is why the decoded strobes must never show more than one operation at once. They also assume that once reset is released it stays released, so the first property window after reset compares against post-reset state only. The stimulus drives every input on the falling clock edge and drops wrValid between commands. It presents unknown selectors and valid-low writes only while holding defined data, so that the hold properties see a well-formed idle cycle.

// File: rtl/camStepPkg.sv
package camStepPkg;

  localparam int WORD_W = 64;
  localparam int HALF_W = WORD_W / 2;
  localparam int BYTE_N = WORD_W / 8;

  typedef struct packed {
    logic doRound;
    logic doFl;
    logic doFlInv;
    logic load0;
    logic load1;
  } camStrobe_t;

  typedef enum logic [1:0] { SB_ONE = 2'd0, SB_TWO = 2'd1, SB_THREE = 2'd2, SB_FOUR = 2'd3 } sboxKind_e;

  // Substitution table split in four quarters indexed by the low six bits.
  localparam logic [7:0] S1_Q0 [64] = '{
    8'd112, 8'd130, 8'd44,  8'd236, 8'd179, 8'd39,  8'd192, 8'd229,
    8'd228, 8'd133, 8'd87,  8'd53,  8'd234, 8'd12,  8'd174, 8'd65,
    8'd35,  8'd239, 8'd107, 8'd147, 8'd69,  8'd25,  8'd165, 8'd33,
    8'd237, 8'd14,  8'd79,  8'd78,  8'd29,  8'd101, 8'd146, 8'd189,
    8'd134, 8'd184, 8'd175, 8'd143, 8'd124, 8'd235, 8'd31,  8'd206,
    8'd62,  8'd48,  8'd220, 8'd95,  8'd94,  8'd197, 8'd11,  8'd26,
    8'd166, 8'd225, 8'd57,  8'd202, 8'd213, 8'd71,  8'd93,  8'd61,
    8'd217, 8'd1,   8'd90,  8'd214, 8'd81,  8'd86,  8'd108, 8'd77
  };
  localparam logic [7:0] S1_Q1 [64] = '{
    8'd139, 8'd13,  8'd154, 8'd102, 8'd251, 8'd204, 8'd176, 8'd45,
    8'd116, 8'd18,  8'd43,  8'd32,  8'd240, 8'd177, 8'd132, 8'd153,
    8'd223, 8'd76,  8'd203, 8'd194, 8'd52,  8'd126, 8'd118, 8'd5,
    8'd109, 8'd183, 8'd169, 8'd49,  8'd209, 8'd23,  8'd4,   8'd215,
    8'd20,  8'd88,  8'd58,  8'd97,  8'd222, 8'd27,  8'd17,  8'd28,
    8'd50,  8'd15,  8'd156, 8'd22,  8'd83,  8'd24,  8'd242, 8'd34,
    8'd254, 8'd68,  8'd207, 8'd178, 8'd195, 8'd181, 8'd122, 8'd145,
    8'd36,  8'd8,   8'd232, 8'd168, 8'd96,  8'd252, 8'd105, 8'd80
  };
  localparam logic [7:0] S1_Q2 [64] = '{
    8'd170, 8'd208, 8'd160, 8'd125, 8'd161, 8'd137, 8'd98,  8'd151,
    8'd84,  8'd91,  8'd30,  8'd149, 8'd224, 8'd255, 8'd100, 8'd210,
    8'd16,  8'd196, 8'd0,   8'd72,  8'd163, 8'd247, 8'd117, 8'd219,
    8'd138, 8'd3,   8'd230, 8'd218, 8'd9,   8'd63,  8'd221, 8'd148,
    8'd135, 8'd92,  8'd131, 8'd2,   8'd205, 8'd74,  8'd144, 8'd51,
    8'd115, 8'd103, 8'd246, 8'd243, 8'd157, 8'd127, 8'd191, 8'd226,
    8'd82,  8'd155, 8'd216, 8'd38,  8'd200, 8'd55,  8'd198, 8'd59,
    8'd129, 8'd150, 8'd111, 8'd75,  8'd19,  8'd190, 8'd99,  8'd46
  };
  localparam logic [7:0] S1_Q3 [64] = '{
    8'd233, 8'd121, 8'd167, 8'd140, 8'd159, 8'd110, 8'd188, 8'd142,
    8'd41,  8'd245, 8'd249, 8'd182, 8'd47,  8'd253, 8'd180, 8'd89,
    8'd120, 8'd152, 8'd6,   8'd106, 8'd231, 8'd70,  8'd113, 8'd186,
    8'd212, 8'd37,  8'd171, 8'd66,  8'd136, 8'd162, 8'd141, 8'd250,
    8'd114, 8'd7,   8'd185, 8'd85,  8'd248, 8'd238, 8'd172, 8'd10,
    8'd54,  8'd73,  8'd42,  8'd104, 8'd60,  8'd56,  8'd241, 8'd164,
    8'd64,  8'd40,  8'd211, 8'd123, 8'd187, 8'd201, 8'd67,  8'd193,
    8'd21,  8'd227, 8'd173, 8'd244, 8'd119, 8'd199, 8'd128, 8'd158
  };

  function automatic logic [7:0] baseSbox(input logic [7:0] x);
    logic [7:0] r;
    case (x[7:6])
      2'd0:    r = S1_Q0[x[5:0]];
      2'd1:    r = S1_Q1[x[5:0]];
      2'd2:    r = S1_Q2[x[5:0]];
      default: r = S1_Q3[x[5:0]];
    endcase
    return r;
  endfunction

  function automatic logic [7:0] variantSbox(input sboxKind_e kind, input logic [7:0] x);
    logic [7:0] s;
    logic [7:0] r;
    s = baseSbox(x);
    case (kind)
      SB_TWO:   r = {s[6:0], s[7]};
      SB_THREE: r = {s[0], s[7:1]};
      SB_FOUR:  r = baseSbox({x[6:0], x[7]});
      default:  r = s;
    endcase
    return r;
  endfunction

  function automatic logic [HALF_W-1:0] rotl1Half(input logic [HALF_W-1:0] v);
    return {v[HALF_W-2:0], v[HALF_W-1]};
  endfunction

  function automatic logic [WORD_W-1:0] flForward(input logic [WORD_W-1:0] d, input logic [WORD_W-1:0] k);
    logic [HALF_W-1:0] hi, lo;
    hi = d[WORD_W-1:HALF_W];
    lo = d[HALF_W-1:0];
    lo = lo ^ rotl1Half(hi & k[WORD_W-1:HALF_W]);
    hi = hi ^ (lo | k[HALF_W-1:0]);
    return {hi, lo};
  endfunction

  function automatic logic [WORD_W-1:0] flInverse(input logic [WORD_W-1:0] d, input logic [WORD_W-1:0] k);
    logic [HALF_W-1:0] hi, lo;
    hi = d[WORD_W-1:HALF_W];
    lo = d[HALF_W-1:0];
    hi = hi ^ (lo | k[HALF_W-1:0]);
    lo = lo ^ rotl1Half(hi & k[WORD_W-1:HALF_W]);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/camStepDecode.sv
module camStepDecode
  import camStepPkg::*;
#(
  parameter int SEL_W = 16,
  parameter logic [SEL_W-1:0] SEL_LOAD0 = 16'h0100,
  parameter logic [SEL_W-1:0] SEL_LOAD1 = 16'h0101,
  parameter logic [SEL_W-1:0] SEL_FL    = 16'h0115,
  parameter logic [SEL_W-1:0] SEL_FLINV = 16'h0116,
  parameter logic [SEL_W-1:0] SEL_ROUND = 16'h3114
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic [SEL_W-1:0] wrSel,
  output camStrobe_t       strobe
);

  always_comb begin
    strobe = '0;
    if (wrValid) begin
      unique case (wrSel)
        SEL_ROUND: strobe.doRound = 1'b1;
        SEL_FL:    strobe.doFl    = 1'b1;
        SEL_FLINV: strobe.doFlInv = 1'b1;
        SEL_LOAD0: strobe.load0   = 1'b1;
        SEL_LOAD1: strobe.load1   = 1'b1;
        default:   strobe = '0;
      endcase
    end
  end

  // R8: at most one operation is ever requested, and none without valid
  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.doRound, strobe.doFl, strobe.doFlInv, strobe.load0, strobe.load1}));
  a_r8_no_valid_no_op: assert property (@(posedge clk) disable iff (!rstN)
    !wrValid |-> (strobe == '0));

endmodule

// File: rtl/camFeistelF.sv
module camFeistelF
  import camStepPkg::*;
(
  input  logic [WORD_W-1:0] dataIn,
  input  logic [WORD_W-1:0] subKey,
  output logic [WORD_W-1:0] fOut
);

  localparam sboxKind_e KIND_ORDER [BYTE_N] = '{SB_ONE, SB_TWO, SB_THREE, SB_FOUR,
                                                SB_TWO, SB_THREE, SB_FOUR, SB_ONE};

  logic [WORD_W-1:0] keyed;
  logic [7:0] tByte [BYTE_N];
  logic [7:0] yByte [BYTE_N];

  assign keyed = dataIn ^ subKey;

  // tByte[0] takes the most significant byte
  for (genvar i = 0; i < BYTE_N; i++) begin : gSbox
    assign tByte[i] = variantSbox(KIND_ORDER[i], keyed[WORD_W-1-8*i -: 8]);
  end

  always_comb begin
    yByte[0] = tByte[0] ^ tByte[2] ^ tByte[3] ^ tByte[5] ^ tByte[6] ^ tByte[7];
    yByte[1] = tByte[0] ^ tByte[1] ^ tByte[3] ^ tByte[4] ^ tByte[6] ^ tByte[7];
    yByte[2] = tByte[0] ^ tByte[1] ^ tByte[2] ^ tByte[4] ^ tByte[5] ^ tByte[7];
    yByte[3] = tByte[1] ^ tByte[2] ^ tByte[3] ^ tByte[4] ^ tByte[5] ^ tByte[6];
    yByte[4] = tByte[0] ^ tByte[1] ^ tByte[5] ^ tByte[6] ^ tByte[7];
    yByte[5] = tByte[1] ^ tByte[2] ^ tByte[4] ^ tByte[6] ^ tByte[7];
    yByte[6] = tByte[2] ^ tByte[3] ^ tByte[4] ^ tByte[5] ^ tByte[7];
    yByte[7] = tByte[0] ^ tByte[3] ^ tByte[4] ^ tByte[5] ^ tByte[6];
  end

  for (genvar j = 0; j < BYTE_N; j++) begin : gPack
    assign fOut[WORD_W-1-8*j -: 8] = yByte[j];
  end

endmodule

// File: rtl/camStepDatapath.sv
module camStepDatapath
  import camStepPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  camStrobe_t        strobe,
  input  logic [WORD_W-1:0] operand,
  input  logic              rdSel,
  output logic [WORD_W-1:0] rdData
);

  logic [WORD_W-1:0] leftQ, rightQ;
  logic [WORD_W-1:0] fValue;
  logic [WORD_W-1:0] flValue, flInvValue;

  camFeistelF uFeistel (
    .dataIn (leftQ),
    .subKey (operand),
    .fOut   (fValue)
  );

  assign flValue    = flForward(leftQ, operand);
  assign flInvValue = flInverse(rightQ, operand);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      leftQ  <= '0;
      rightQ <= '0;
    end else begin
      if (strobe.doRound) begin
        leftQ  <= rightQ ^ fValue;
        rightQ <= leftQ;
      end
      if (strobe.doFl)    leftQ  <= flValue;
      if (strobe.doFlInv) rightQ <= flInvValue;
      if (strobe.load0)   leftQ  <= operand;
      if (strobe.load1)   rightQ <= operand;
    end
  end

  assign rdData = rdSel ? rightQ : leftQ;

  // R3: the round moves the old left word into the right word
  a_r3_round_swap: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doRound |=> rightQ == $past(leftQ));
  // R6: forward FL touches only the left word
  a_r6_fl_keeps_right: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doFl |=> rightQ == $past(rightQ));
  // R7: inverse FL touches only the right word
  a_r7_flinv_keeps_left: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doFlInv |=> leftQ == $past(leftQ));
  // R2: direct loads land in the named word
  a_r2_load_left: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load0 |=> leftQ == $past(operand));
  a_r2_load_right: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load1 |=> rightQ == $past(operand));
  // R8: an idle cycle holds the state
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strobe == '0) |=> ($stable(leftQ) && $stable(rightQ)));

endmodule

// File: rtl/camStepEngine.sv
module camStepEngine
  import camStepPkg::*;
#(
  parameter int SEL_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [WORD_W-1:0] wrData,
  input  logic              rdSel,
  output logic [WORD_W-1:0] rdData
);

  camStrobe_t strobe;

  camStepDecode #(.SEL_W(SEL_W)) uDecode (
    .clk     (clk),
    .rstN    (rstN),
    .wrValid (wrValid),
    .wrSel   (wrSel),
    .strobe  (strobe)
  );

  camStepDatapath uDatapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .operand (wrData),
    .rdSel   (rdSel),
    .rdData  (rdData)
  );

endmodule

// File: tb/camStepEngine_test.sv
`timescale 1ns/1ps
module camStepEngine_test;

  localparam logic [15:0] S_LOAD0 = 16'h0100;
  localparam logic [15:0] S_LOAD1 = 16'h0101;
  localparam logic [15:0] S_FL    = 16'h0115;
  localparam logic [15:0] S_FLINV = 16'h0116;
  localparam logic [15:0] S_ROUND = 16'h3114;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [15:0] wrSel = '0;
  logic [63:0] wrData = '0;
  logic        rdSel = 1'b0;
  logic [63:0] rdData;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  camStepEngine uut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrSel(wrSel),
    .wrData(wrData), .rdSel(rdSel), .rdData(rdData)
  );

  task automatic check64(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic issue(input logic [15:0] sel, input logic [63:0] data, input logic valid = 1'b1);
    @(negedge clk);
    wrValid = valid;
    wrSel   = sel;
    wrData  = data;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic readWord(input logic which, output logic [63:0] value);
    rdSel = which;
    #1;
    value = rdData;
  endtask

  function automatic logic [63:0] flModel(input logic [63:0] d, input logic [63:0] k);
    logic [31:0] hi, lo, t;
    hi = d[63:32]; lo = d[31:0];
    t  = hi & k[63:32];
    lo = lo ^ {t[30:0], t[31]};
    hi = hi ^ (lo | k[31:0]);
    return {hi, lo};
  endfunction

  function automatic logic [127:0] rotl128(input logic [127:0] v, input int n);
    return (v << n) | (v >> (128 - n));
  endfunction

  task automatic testReset();
    logic [63:0] v;
    readWord(1'b0, v); check64("R1 left after reset", v, 64'h0);
    readWord(1'b1, v); check64("R1 right after reset", v, 64'h0);
  endtask

  task automatic testLoad();
    logic [63:0] v;
    issue(S_LOAD0, 64'hA5A5_0000_1234_FFFF);
    issue(S_LOAD1, 64'h0F0F_9999_8765_0001);
    readWord(1'b0, v); check64("R2 load left", v, 64'hA5A5_0000_1234_FFFF);
    readWord(1'b1, v); check64("R2 load right", v, 64'h0F0F_9999_8765_0001);
  endtask

  task automatic testZeroRound();
    logic [63:0] v;
    issue(S_LOAD0, 64'h0);
    issue(S_LOAD1, 64'h1111_1111_1111_1111);
    issue(S_ROUND, 64'h0);
    readWord(1'b0, v); check64("R3 R4 R5 round with F(0,0)", v, 64'h1111_1111_B929_F1B9);
    readWord(1'b1, v); check64("R3 round moves left to right", v, 64'h0);
  endtask

  task automatic testFlPair();
    logic [63:0] v, fwd;
    logic [63:0] orig = 64'hDEAD_BEEF_0BAD_F00D;
    logic [63:0] key  = 64'h8421_0FF0_1357_9BDF;
    logic [63:0] other = 64'h5555_AAAA_3333_CCCC;
    issue(S_LOAD0, orig);
    issue(S_LOAD1, other);
    issue(S_FL, key);
    readWord(1'b0, fwd); check64("R6 FL on left", fwd, flModel(orig, key));
    readWord(1'b1, v);   check64("R6 FL leaves right", v, other);
    issue(S_LOAD1, fwd);
    issue(S_FLINV, key);
    readWord(1'b1, v);   check64("R7 FLINV undoes FL", v, orig);
    readWord(1'b0, v);   check64("R7 FLINV leaves left", v, fwd);
  endtask

  task automatic testIgnored();
    logic [63:0] v;
    issue(S_LOAD0, 64'h0123_0123_0123_0123);
    issue(S_LOAD1, 64'h4567_4567_4567_4567);
    issue(16'h0117, 64'hFFFF_FFFF_FFFF_FFFF);
    issue(16'h3115, 64'hFFFF_FFFF_FFFF_FFFF);
    issue(16'h0000, 64'hFFFF_FFFF_FFFF_FFFF);
    issue(S_ROUND, 64'h7777_7777_7777_7777, 1'b0);
    issue(S_LOAD0, 64'h9999_9999_9999_9999, 1'b0);
    readWord(1'b0, v); check64("R8 left held", v, 64'h0123_0123_0123_0123);
    readWord(1'b1, v); check64("R8 right held", v, 64'h4567_4567_4567_4567);
  endtask

  task automatic testCipher();
    logic [127:0] kl = 128'h0123456789ABCDEFFEDCBA9876543210;
    logic [127:0] pt = 128'h0123456789ABCDEFFEDCBA9876543210;
    logic [127:0] ka, r;
    logic [63:0]  w0, w1;
    logic [63:0]  rk [18];
    logic [63:0]  ke [4];
    logic [63:0]  kw [4];
    // key schedule intermediate derived through the engine itself
    issue(S_LOAD0, kl[127:64]);
    issue(S_LOAD1, kl[63:0]);
    issue(S_ROUND, 64'hA09E667F3BCC908B);
    issue(S_ROUND, 64'hB67AE8584CAA73B2);
    readWord(1'b0, w0); readWord(1'b1, w1);
    issue(S_LOAD0, w0 ^ kl[127:64]);
    issue(S_LOAD1, w1 ^ kl[63:0]);
    issue(S_ROUND, 64'hC6EF372FE94F82BE);
    issue(S_ROUND, 64'h54FF53A5F1D36F1C);
    readWord(1'b0, w0); readWord(1'b1, w1);
    ka = {w0, w1};
    kw[0] = kl[127:64]; kw[1] = kl[63:0];
    rk[0] = ka[127:64]; rk[1] = ka[63:0];
    r = rotl128(kl, 15);  rk[2] = r[127:64]; rk[3] = r[63:0];
    r = rotl128(ka, 15);  rk[4] = r[127:64]; rk[5] = r[63:0];
    r = rotl128(ka, 30);  ke[0] = r[127:64]; ke[1] = r[63:0];
    r = rotl128(kl, 45);  rk[6] = r[127:64]; rk[7] = r[63:0];
    r = rotl128(ka, 45);  rk[8] = r[127:64];
    r = rotl128(kl, 60);  rk[9] = r[63:0];
    r = rotl128(ka, 60);  rk[10] = r[127:64]; rk[11] = r[63:0];
    r = rotl128(kl, 77);  ke[2] = r[127:64]; ke[3] = r[63:0];
    r = rotl128(kl, 94);  rk[12] = r[127:64]; rk[13] = r[63:0];
    r = rotl128(ka, 94);  rk[14] = r[127:64]; rk[15] = r[63:0];
    r = rotl128(kl, 111); rk[16] = r[127:64]; rk[17] = r[63:0];
    r = rotl128(ka, 111); kw[2] = r[127:64]; kw[3] = r[63:0];
    issue(S_LOAD0, pt[127:64] ^ kw[0]);
    issue(S_LOAD1, pt[63:0] ^ kw[1]);
    for (int i = 0; i < 18; i++) begin
      issue(S_ROUND, rk[i]);
      if (i == 5)  begin issue(S_FL, ke[0]); issue(S_FLINV, ke[1]); end
      if (i == 11) begin issue(S_FL, ke[2]); issue(S_FLINV, ke[3]); end
    end
    readWord(1'b0, w0); readWord(1'b1, w1);
    check64("R9 ciphertext high", w1 ^ kw[2], 64'h6767313854966973);
    check64("R9 ciphertext low",  w0 ^ kw[3], 64'h0857065648EABE43);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLoad();
    testZeroRound();
    testFlPair();
    testIgnored();
    testCipher();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule